// File: doc/BRIEF.md
# Fractional-Rate Time-of-Day Clock

This block keeps a 24-hour time of day as packed BCD hours, minutes and seconds. It can run from any system clock rate. On every system clock a programmable rate word is added into a wide phase accumulator. Each carry out of the accumulator's top bit counts as one second.

A Wishbone slave port with 32-bit word access sets and reads the time, the alarm and the rate word. The same port also returns a snapshot that is taken when the hack input is strobed. A one-cycle interrupt pulse marks the moment the time reaches the enabled alarm time. A one-cycle day strobe lets a separate calendar block advance its date on the same edge on which this clock wraps to midnight.

The accumulator has two parts. The lower part holds the fine phase. The upper part belongs to the time counter, and a write to the time register clears it.

Top module: `tod_clock`

## Requirements
- R1: A request with both cycle and strobe high gets `wb_ack_o` high on the next cycle only. Read data is valid in that same cycle. `wb_stall_o` is always 0.
- R2: The time register is at word 0 and holds BCD hours in bits 21:16, minutes in bits 14:8 and seconds in bits 6:0. All other bits read as zero. A write sets these fields and a read returns them.
- R3: When a written time field is all ones (hours 6'h3f, minutes 7'h7f, seconds 7'h7f), that field keeps its current value and the other fields are still written.
- R4: The rate word is at word 2. The seconds value advances once for each carry out of the accumulator, which is `FRAC_W+UPPER_W` bits wide and gains the rate word every cycle. A time write clears the upper `UPPER_W` bits, so the first second after the write lasts exactly 2^ACC_W / rate cycles when the rate is a multiple of 2^FRAC_W.
- R5: Seconds carry into minutes after 59, and minutes carry into hours after 59, with BCD digits throughout.
- R6: From 23:59:59 the next second gives 00:00:00.
- R7: `ppd_o` is high for exactly one cycle, the cycle just before the time changes from 23:59:59 to 00:00:00.
- R8: The alarm register is at word 1. It has the same time fields as word 0, an enable in bit 24 and a triggered flag in bit 25. When enabled, `irq_o` is high for one cycle, the first cycle in which the time equals the alarm time after a tick, and the flag becomes 1.
- R9: While the flag is set, no further interrupt fires. Writing 1 to bit 25 clears the flag, and after that the alarm can fire again. With the enable at 0, no interrupt fires.
- R10: A cycle with `hack_i` high captures the time at word 3 and the accumulator at word 4 (bits above 32) and word 5 (low 32 bits), as they stood at that edge. The captured values then hold until the next hack.
- R11: After reset the time, rate word, alarm, enable and flag are all zero, and `ppd_o`, `irq_o` and `wb_ack_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | ADDR_W | Word address |
| wb_dat_i | input | 32 | Write data |
| wb_ack_o | output | 1 | Access acknowledge, one cycle after the request |
| wb_stall_o | output | 1 | Always zero |
| wb_dat_o | output | 32 | Read data |
| hack_i | input | 1 | Snapshot strobe |
| ppd_o | output | 1 | Day strobe, high in the cycle before midnight |
| irq_o | output | 1 | Alarm interrupt pulse |

## Verification
If the accumulator phase is wrong, the first second after a time write comes at the wrong cycle. A read some cycles later then shows a seconds count that is off by one. A BCD carry fault shows at the first read after the tick that crosses the affected digit. If the triggered flag or the day strobe sticks, a pulse lasts too long or repeats, and this shows within one second of the event. A bad snapshot capture shows at the next read of word 3 or word 5.

// File: rtl/tod_pkg.sv
package tod_pkg;
  typedef struct packed {
    logic [5:0] hr;
    logic [6:0] mn;
    logic [6:0] sc;
  } tod_time_t;

  localparam int ADR_TIME  = 0;
  localparam int ADR_ALARM = 1;
  localparam int ADR_SPEED = 2;
  localparam int ADR_HTIME = 3;
  localparam int ADR_HHI   = 4;
  localparam int ADR_HLO   = 5;

  localparam int BIT_AL_EN   = 24;
  localparam int BIT_AL_FLAG = 25;

  localparam tod_time_t TOD_LAST = '{hr: 6'h23, mn: 7'h59, sc: 7'h59};

  function automatic tod_time_t word_to_time(input logic [31:0] w);
    return '{hr: w[21:16], mn: w[14:8], sc: w[6:0]};
  endfunction

  function automatic logic [21:0] time_to_bits(input tod_time_t t);
    return {t.hr, 1'b0, t.mn, 1'b0, t.sc};
  endfunction

  // BCD +1 second with 24 h wrap
  function automatic tod_time_t tod_next(input tod_time_t t);
    tod_time_t n;
    logic s_wrap, m_wrap;
    n = t;
    s_wrap = (t.sc == 7'h59);
    m_wrap = (t.mn == 7'h59);
    if (s_wrap) n.sc = '0;
    else if (t.sc[3:0] == 4'd9) n.sc = {3'(t.sc[6:4] + 3'd1), 4'd0};
    else n.sc = {t.sc[6:4], 4'(t.sc[3:0] + 4'd1)};
    if (s_wrap) begin
      if (m_wrap) n.mn = '0;
      else if (t.mn[3:0] == 4'd9) n.mn = {3'(t.mn[6:4] + 3'd1), 4'd0};
      else n.mn = {t.mn[6:4], 4'(t.mn[3:0] + 4'd1)};
    end
    if (s_wrap && m_wrap) begin
      if (t.hr == 6'h23) n.hr = '0;
      else if (t.hr[3:0] == 4'd9) n.hr = {2'(t.hr[5:4] + 2'd1), 4'd0};
      else n.hr = {t.hr[5:4], 4'(t.hr[3:0] + 4'd1)};
    end
    return n;
  endfunction
endpackage

// File: rtl/tod_phase.sv
module tod_phase #(
  parameter int FRAC_W  = 40,
  parameter int UPPER_W = 8,
  parameter int SPEED_W = 32,
  localparam int ACC_W  = FRAC_W + UPPER_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SPEED_W-1:0] speed_i,
  input  logic               restart_i,
  output logic               tick_o,
  output logic [ACC_W-1:0]   acc_o
);
  localparam int SUM_W = ACC_W + 1;

  logic [ACC_W-1:0] acc_q;
  logic [SUM_W-1:0] sum;

  assign sum    = {1'b0, acc_q} + SUM_W'(speed_i);
  assign tick_o = sum[ACC_W];
  assign acc_o  = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        acc_q <= '0;
    else if (restart_i) acc_q <= {{UPPER_W{1'b0}}, sum[FRAC_W-1:0]};
    else                acc_q <= sum[ACC_W-1:0];
  end
endmodule

// File: rtl/tod_time.sv
module tod_time
  import tod_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      we_i,
  input  tod_time_t wtime_i,
  output tod_time_t time_o,
  output tod_time_t next_o
);
  tod_time_t time_q;

  assign next_o = tod_next(time_q);
  assign time_o = time_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) time_q <= '0;
    else if (we_i) begin
      if (wtime_i.hr != '1) time_q.hr <= wtime_i.hr;
      if (wtime_i.mn != '1) time_q.mn <= wtime_i.mn;
      if (wtime_i.sc != '1) time_q.sc <= wtime_i.sc;
    end else if (tick_i) time_q <= next_o;
  end
endmodule

// File: rtl/tod_alarm.sv
module tod_alarm
  import tod_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      step_i,
  input  tod_time_t next_i,
  input  logic      we_i,
  input  tod_time_t wtime_i,
  input  logic      wen_i,
  input  logic      wclr_i,
  output tod_time_t alarm_o,
  output logic      en_o,
  output logic      flag_o,
  output logic      irq_o
);
  tod_time_t alarm_q;
  logic en_q, flag_q, irq_q, hit;

  assign hit     = step_i && en_q && !flag_q && (next_i == alarm_q);
  assign alarm_o = alarm_q;
  assign en_o    = en_q;
  assign flag_o  = flag_q;
  assign irq_o   = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alarm_q <= '0;
      en_q    <= 1'b0;
      flag_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= hit;
      if (we_i) begin
        alarm_q <= wtime_i;
        en_q    <= wen_i;
      end
      // set wins over a same-cycle clear
      if (hit)                flag_q <= 1'b1;
      else if (we_i && wclr_i) flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tod_clock.sv
module tod_clock
  import tod_pkg::*;
#(
  parameter int FRAC_W  = 40,
  parameter int UPPER_W = 8,
  parameter int SPEED_W = 32,
  parameter int ADDR_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wb_cyc_i,
  input  logic              wb_stb_i,
  input  logic              wb_we_i,
  input  logic [ADDR_W-1:0] wb_adr_i,
  input  logic [31:0]       wb_dat_i,
  output logic              wb_ack_o,
  output logic              wb_stall_o,
  output logic [31:0]       wb_dat_o,
  input  logic              hack_i,
  output logic              ppd_o,
  output logic              irq_o
);
  localparam int ACC_W = FRAC_W + UPPER_W;

  logic req, time_we, alarm_we, speed_we, tick, step;
  logic [SPEED_W-1:0] speed_q;
  logic [ACC_W-1:0]   acc;
  logic [ACC_W-1:0]   hack_acc_q;
  logic [63:0]        hack_ext;
  tod_time_t time_q, next_time, alarm_t, hack_time_q, wtime;
  logic al_en, al_flag, ack_q;
  logic [31:0] rdata_q;

  assign req      = wb_cyc_i && wb_stb_i;
  assign time_we  = req && wb_we_i && (wb_adr_i == ADDR_W'(ADR_TIME));
  assign alarm_we = req && wb_we_i && (wb_adr_i == ADDR_W'(ADR_ALARM));
  assign speed_we = req && wb_we_i && (wb_adr_i == ADDR_W'(ADR_SPEED));
  assign wtime    = word_to_time(wb_dat_i);
  assign step     = tick && !time_we;

  tod_phase #(.FRAC_W(FRAC_W), .UPPER_W(UPPER_W), .SPEED_W(SPEED_W)) u_phase (
    .clk_i, .rst_ni, .speed_i(speed_q), .restart_i(time_we),
    .tick_o(tick), .acc_o(acc)
  );

  tod_time u_time (
    .clk_i, .rst_ni, .tick_i(tick), .we_i(time_we), .wtime_i(wtime),
    .time_o(time_q), .next_o(next_time)
  );

  tod_alarm u_alarm (
    .clk_i, .rst_ni, .step_i(step), .next_i(next_time), .we_i(alarm_we),
    .wtime_i(wtime), .wen_i(wb_dat_i[BIT_AL_EN]), .wclr_i(wb_dat_i[BIT_AL_FLAG]),
    .alarm_o(alarm_t), .en_o(al_en), .flag_o(al_flag), .irq_o(irq_o)
  );

  assign ppd_o = step && (time_q == TOD_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      speed_q     <= '0;
      hack_time_q <= '0;
      hack_acc_q  <= '0;
    end else begin
      if (speed_we) speed_q <= wb_dat_i[SPEED_W-1:0];
      if (hack_i) begin
        hack_time_q <= time_q;
        hack_acc_q  <= acc;
      end
    end
  end

  assign hack_ext = 64'(hack_acc_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q <= req;
      if (req) begin
        case (int'(wb_adr_i))
          ADR_TIME:  rdata_q <= {10'b0, time_to_bits(time_q)};
          ADR_ALARM: rdata_q <= {6'b0, al_flag, al_en, 2'b0, time_to_bits(alarm_t)};
          ADR_SPEED: rdata_q <= 32'(speed_q);
          ADR_HTIME: rdata_q <= {10'b0, time_to_bits(hack_time_q)};
          ADR_HHI:   rdata_q <= hack_ext[63:32];
          ADR_HLO:   rdata_q <= hack_ext[31:0];
          default:   rdata_q <= '0;
        endcase
      end
    end
  end

  assign wb_ack_o   = ack_q;
  assign wb_stall_o = 1'b0;
  assign wb_dat_o   = rdata_q;
endmodule

// File: rtl/tod_clock_chk.sv
module tod_clock_chk
  import tod_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      req,
  input logic      wb_ack_o,
  input logic      wb_stall_o,
  input logic      ppd_o,
  input logic      irq_o,
  input logic      hack_i,
  input logic      tick,
  input logic      time_we,
  input tod_time_t time_q,
  input tod_time_t hack_time_q
);
  p_ack_next_r1: assert property (@(posedge clk_i) disable iff (!rst_ni) req |=> wb_ack_o);
  p_ack_only_r1: assert property (@(posedge clk_i) disable iff (!rst_ni) !req |=> !wb_ack_o);
  p_stall_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni) !wb_stall_o);
  p_time_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick && !time_we) |=> $stable(time_q));
  p_wrap_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ppd_o |=> (time_q == '0));
  p_ppd_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni) ppd_o |=> !ppd_o);
  p_irq_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni) irq_o |=> !irq_o);
  p_hack_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hack_i |=> $stable(hack_time_q));
endmodule

bind tod_clock tod_clock_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req(req), .wb_ack_o(wb_ack_o),
  .wb_stall_o(wb_stall_o), .ppd_o(ppd_o), .irq_o(irq_o), .hack_i(hack_i),
  .tick(tick), .time_we(time_we), .time_q(time_q), .hack_time_q(hack_time_q)
);

// File: tb/sim_tod_clock.sv
module sim_tod_clock;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cyc = 0, stb = 0, we = 0, hack = 0;
  logic [2:0] adr = '0;
  logic [31:0] wdat = '0;
  logic ack, stall, ppd, irq;
  logic [31:0] rdat;
  int total = 0, bad = 0;
  int ppd_hi = 0, irq_hi = 0, irq_rise = 0;
  logic irq_d = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  // 16-bit accumulator so that seconds are short
  tod_clock #(.FRAC_W(8), .UPPER_W(8), .SPEED_W(16), .ADDR_W(3)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_dat_i(wdat), .wb_ack_o(ack), .wb_stall_o(stall),
    .wb_dat_o(rdat), .hack_i(hack), .ppd_o(ppd), .irq_o(irq)
  );

  always @(negedge clk) begin
    if (ppd) ppd_hi++;
    if (irq) irq_hi++;
    if (irq && !irq_d) irq_rise++;
    irq_d <= irq;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cyc = 1; stb = 1; we = 1; adr = a; wdat = d;
    @(posedge clk); #1 cyc = 0; stb = 0; we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); cyc = 1; stb = 1; we = 0; adr = a;
    @(posedge clk); #1 cyc = 0; stb = 0;
    @(negedge clk); d = rdat;
  endtask

  task automatic t_reset;
    chk("R11 ppd", 32'(ppd), 0);
    chk("R11 irq", 32'(irq), 0);
    chk("R11 ack", 32'(ack), 0);
    rd(0, rv); chk("R11 time", rv, 32'h0);
    rd(1, rv); chk("R11 alarm", rv, 32'h0);
    rd(2, rv); chk("R11 speed", rv, 32'h0);
  endtask

  task automatic t_bus;
    @(negedge clk); cyc = 1; stb = 1; we = 0; adr = 3'd2;
    chk("R1 stall", 32'(stall), 0);
    chk("R1 ack not early", 32'(ack), 0);
    @(posedge clk); #1 cyc = 0; stb = 0;
    @(negedge clk); chk("R1 ack", 32'(ack), 1);
    @(negedge clk); chk("R1 ack single", 32'(ack), 0);
    @(negedge clk); cyc = 1; stb = 0;
    @(negedge clk); chk("R1 no ack without stb", 32'(ack), 0); cyc = 0;
  endtask

  task automatic t_fields;
    wr(0, 32'h0012_3456); rd(0, rv); chk("R2 time write", rv, 32'h0012_3456);
    wr(0, 32'h003F_7F07); rd(0, rv); chk("R3 keep hr mn", rv, 32'h0012_3407);
    wr(0, 32'h0008_7F7F); rd(0, rv); chk("R3 keep mn sc", rv, 32'h0008_3407);
  endtask

  task automatic t_rate;
    wr(2, 32'h1000);
    wr(0, 32'h0009_5959);              // tick 16 cycles after write
    repeat (20) @(negedge clk);
    rd(0, rv); chk("R5 carry to hour", rv, 32'h0010_0000);
    wr(0, 32'h0012_4959);
    repeat (20) @(negedge clk);
    rd(0, rv); chk("R5 carry to minute", rv, 32'h0012_5000);
    wr(0, 32'h0000_0000);
    repeat (36) @(negedge clk);
    rd(0, rv); chk("R4 two seconds at 16 cyc", rv, 32'h0000_0002);
    wr(2, 32'h0800);
    wr(0, 32'h0000_0000);              // 32 cycles per second
    repeat (36) @(negedge clk);
    rd(0, rv); chk("R4 one second at 32 cyc", rv, 32'h0000_0001);
    wr(2, 32'h0);
    wr(0, 32'h0000_0000);
    repeat (70) @(negedge clk);
    rd(0, rv); chk("R4 zero rate holds", rv, 32'h0);
  endtask

  task automatic t_midnight;
    int p0;
    p0 = ppd_hi;
    wr(2, 32'h1000);
    wr(0, 32'h0023_5958);
    repeat (24) @(negedge clk);
    chk("R7 no early ppd", 32'(ppd_hi - p0), 0);
    repeat (12) @(negedge clk);
    rd(0, rv); chk("R6 wrap to 00:00:00", rv, 32'h0);
    chk("R7 ppd one cycle", 32'(ppd_hi - p0), 1);
    wr(2, 32'h0);
  endtask

  task automatic t_alarm;
    int r0;
    r0 = irq_rise;
    wr(2, 32'h1000);
    wr(1, 32'h0100_0003);
    wr(0, 32'h0);
    repeat (60) @(negedge clk);
    chk("R8 irq fired once", 32'(irq_rise - r0), 1);
    chk("R8 irq one cycle", 32'(irq_hi), 32'(irq_rise));
    rd(1, rv); chk("R8 flag set", rv, 32'h0300_0003);
    wr(0, 32'h0000_0002);
    repeat (30) @(negedge clk);
    chk("R9 no refire while flagged", 32'(irq_rise - r0), 1);
    wr(1, 32'h0300_0003);
    rd(1, rv); chk("R9 flag cleared", rv, 32'h0100_0003);
    wr(0, 32'h0000_0002);
    repeat (30) @(negedge clk);
    chk("R9 refire after clear", 32'(irq_rise - r0), 2);
    wr(1, 32'h0200_0003);
    wr(0, 32'h0000_0002);
    repeat (30) @(negedge clk);
    chk("R9 disabled no irq", 32'(irq_rise - r0), 2);
    wr(2, 32'h0);
  endtask

  task automatic t_hack;
    wr(2, 32'h1000);
    wr(0, 32'h0011_2233);              // upper part cleared at this edge
    repeat (4) @(negedge clk);
    hack = 1;                          // captured after 3 increments
    @(negedge clk); hack = 0;
    wr(2, 32'h0);
    rd(5, rv); chk("R10 hack low sub-second", rv, 32'h3000);
    rd(4, rv); chk("R10 hack high sub-second", rv, 32'h0);
    rd(3, rv); chk("R10 hack time", rv, 32'h0011_2233);
    wr(0, 32'h0001_0203);
    rd(3, rv); chk("R10 hack holds", rv, 32'h0011_2233);
    @(negedge clk); hack = 1;
    @(negedge clk); hack = 0;
    rd(3, rv); chk("R10 second hack", rv, 32'h0001_0203);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_bus();
    t_fields();
    t_rate();
    t_midnight();
    t_alarm();
    t_hack();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule